// File: doc/BRIEF.md
# Interval Timer with External Event Counting

This block is a 16-bit down-counter with an 8-bit holding register for its low byte. Software first writes the low byte into the holding register, then writes the high byte; the high-byte write copies both bytes into the counter at once. A mode input picks what makes the counter step. In clock mode the counter steps down once per clock, so it works as a one-shot interval timer. In pin mode it steps down once for each falling edge seen on an asynchronous event input, so it counts external events.

Each high-byte load arms the counter once. The first step from zero to all ones sets an expiry flag. Later wraps do not set it again until the next load. A read strobe for the low counter byte clears the flag, and so does a fresh high-byte load. Changing the mode input freezes the count or lets it run again from where it stopped. A surrounding register decoder drives the write strobe, the byte select, the mode input and the read strobe. A separate interrupt combiner consumes the flag.

Top module: `tpc_timer`

## Requirements
- R1: A write with `wr_hi`=0 stores `wr_data` into the low holding register only. The counter and the flag do not change.
- R2: A write with `wr_hi`=1 sets the counter to {`wr_data`, holding register} at that clock edge, clears the flag and arms the counter.
- R3: In clock mode (`pulse_mode`=0), after a high-byte load of value N the counter holds N for one more clock and then decrements once per clock. The flag first reads 1 N+2 clocks after the load edge, and the counter is all ones at that point.
- R4: In pin mode (`pulse_mode`=1), a high-byte load only sets the value. The counter does not move without pin edges.
- R5: When `pulse_mode` goes from 0 to 1, the counter keeps the value it had before that edge and stops following the clock.
- R6: When `pulse_mode` returns to 0, the counter decrements on the very next clock, starting from the held value.
- R7: In pin mode, each falling edge of `ext_pin` decrements the counter by one. The new value appears on the third clock after the pin changes, because the pin passes through two synchroniser flops and an edge detector. Rising edges have no effect.
- R8: An armed step from zero sets the flag in the same clock in which the counter becomes all ones.
- R9: The flag is set at most once per load. The counter keeps decrementing through zero without reloading, and a later wrap leaves a cleared flag at 0.
- R10: A `lo_read` strobe clears the flag at the next edge. If a flag-setting step falls on the same edge, the flag is set.
- R11: While reset is asserted, the counter, the holding register and the flag are 0, and the counter is disarmed. After reset, clock mode counts down from zero and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | 0: step on each clock; 1: step on falling edges of `ext_pin` |
| ext_pin | input | 1 | Asynchronous event input |
| wr_en | input | 1 | Write strobe |
| wr_hi | input | 1 | 0: write the low holding register; 1: write the high byte and load the counter |
| wr_data | input | 8 | Write data byte |
| lo_read | input | 1 | Strobe marking a read of the low counter byte; clears the flag |
| count_o | output | 16 | Current counter value |
| flag_o | output | 1 | Expiry flag |

## Verification
Every counter state bit drives `count_o` directly. A wrong count, a missed start delay or an extra step therefore shows on the port at the next clock, and the bench compares values clock by clock after each load, mode change and pin edge. A wrong arm bit stays hidden until the counter passes zero. It then shows as a missing flag, or as a flag that reappears after a clear. For this reason the bench runs the counter through a whole second wrap of 65536 clocks. A synchroniser fault shifts the pin-mode step by a clock, or makes a rising edge count. The bench checks the clock before and the clock of the expected step.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;

    typedef enum logic {
        CNT_SRC_CLOCK = 1'b0,
        CNT_SRC_PIN   = 1'b1
    } cnt_src_e;

    typedef enum logic {
        WSEL_LATCH_LO = 1'b0,
        WSEL_COUNT_HI = 1'b1
    } wsel_e;

endpackage

// File: rtl/tpc_pin_sync.sv
`timescale 1ns/1ps
module tpc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);

    logic [STAGES-1:0] chain_d, chain_q;
    logic              last_d, last_q;

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = pin_i;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_comb begin
        last_d = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            last_q  <= last_d;
        end
    end

    assign fall_o = last_q & ~chain_q[STAGES-1];

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R7

endmodule

// File: rtl/tpc_count_core.sv
`timescale 1ns/1ps
module tpc_count_core
    import tpc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  wsel_e                 wr_sel,
    input  logic [BYTE_W-1:0]     wr_data,
    input  cnt_src_e              src,
    input  logic                  pin_fall,
    output logic [2*BYTE_W-1:0]   count_o,
    output logic                  load_o,
    output logic                  fire_o
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [BYTE_W-1:0] latch;
        logic              skip;
        logic              armed;
    } core_t;

    core_t cur_q, nxt_d;
    logic  load, latch_wr, step, fire;

    always_comb begin
        nxt_d    = cur_q;
        load     = wr_en && (wr_sel == WSEL_COUNT_HI);
        latch_wr = wr_en && (wr_sel == WSEL_LATCH_LO);
        step     = (src == CNT_SRC_CLOCK) ? !cur_q.skip : pin_fall;
        fire     = 1'b0;

        if (latch_wr) begin
            nxt_d.latch = wr_data;
        end

        if (load) begin
            nxt_d.count = {wr_data, cur_q.latch};
            nxt_d.skip  = (src == CNT_SRC_CLOCK);
            nxt_d.armed = 1'b1;
        end else begin
            nxt_d.skip = 1'b0;
            if (step) begin
                nxt_d.count = cur_q.count - ONE;
                if (cur_q.armed && (cur_q.count == '0)) begin
                    nxt_d.armed = 1'b0;
                    fire        = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign count_o = cur_q.count;
    assign load_o  = load;
    assign fire_o  = fire;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cur_q.count == {$past(wr_data), $past(cur_q.latch)}); // R2

    AST_PIN_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (src == CNT_SRC_PIN && !pin_fall && !load) |=> cur_q.count == $past(cur_q.count)); // R5

    AST_PIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (src == CNT_SRC_PIN && pin_fall && !load) |=> cur_q.count == $past(cur_q.count) - ONE); // R7

endmodule

// File: rtl/tpc_flag_ctl.sv
`timescale 1ns/1ps
module tpc_flag_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic load_i,
    input  logic rd_clr_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (load_i) begin
            flag_d = 1'b0;
        end else if (fire_i) begin
            flag_d = 1'b1;
        end else if (rd_clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !fire_i) |=> !flag_o); // R10

    AST_SET_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> flag_o); // R8

endmodule

// File: rtl/tpc_timer.sv
`timescale 1ns/1ps
module tpc_timer
    import tpc_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pulse_mode,
    input  logic                ext_pin,
    input  logic                wr_en,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                lo_read,
    output logic [2*BYTE_W-1:0] count_o,
    output logic                flag_o
);

    localparam int CNT_W = 2 * BYTE_W;

    cnt_src_e         src;
    wsel_e            wsel;
    logic             pin_fall, load, fire;
    logic [CNT_W-1:0] count;

    assign src  = pulse_mode ? CNT_SRC_PIN : CNT_SRC_CLOCK;
    assign wsel = wr_hi ? WSEL_COUNT_HI : WSEL_LATCH_LO;

    tpc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .fall_o (pin_fall)
    );

    tpc_count_core #(.BYTE_W(BYTE_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wsel),
        .wr_data  (wr_data),
        .src      (src),
        .pin_fall (pin_fall),
        .count_o  (count),
        .load_o   (load),
        .fire_o   (fire)
    );

    tpc_flag_ctl u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .load_i   (load),
        .rd_clr_i (lo_read),
        .flag_o   (flag_o)
    );

    assign count_o = count;

    AST_FLAG_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> count_o == '1); // R8

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_hi) |=> !flag_o); // R2

endmodule

// File: tb/tb_tpc_timer.sv
`timescale 1ns/1ps
module tb_tpc_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pulse_mode;
    logic        ext_pin;
    logic        wr_en;
    logic        wr_hi;
    logic [7:0]  wr_data;
    logic        lo_read;
    logic [15:0] count_o;
    logic        flag_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tpc_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (pulse_mode),
        .ext_pin    (ext_pin),
        .wr_en      (wr_en),
        .wr_hi      (wr_hi),
        .wr_data    (wr_data),
        .lo_read    (lo_read),
        .count_o    (count_o),
        .flag_o     (flag_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic hi, input logic [7:0] d);
        wr_en = 1'b1; wr_hi = hi; wr_data = d;
        step(1);
        wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0;
    endtask

    task automatic rd_strobe();
        lo_read = 1'b1;
        step(1);
        lo_read = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "count in reset", count_o, 16'h0000);
        chk("R11", "flag in reset", flag_o, 1'b0);
        rst_n = 1'b1;
        step(5);
        chk("R11", "free count after reset", count_o, 16'hFFFB);
        chk("R11", "flag stays clear", flag_o, 1'b0);
    endtask

    task automatic t_timer();
        pulse_mode = 1'b0;
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h00);
        chk("R2", "count after load", count_o, 16'h0005);
        chk("R2", "flag after load", flag_o, 1'b0);
        step(1);
        chk("R3", "start delay hold", count_o, 16'h0005);
        step(1);
        chk("R3", "first step", count_o, 16'h0004);
        step(4);
        chk("R3", "count at N+1", count_o, 16'h0000);
        chk("R3", "flag at N+1", flag_o, 1'b0);
        step(1);
        chk("R3", "count at N+2", count_o, 16'hFFFF);
        chk("R3", "flag at N+2", flag_o, 1'b1);
        step(2);
        rd_strobe();
        chk("R10", "flag after read", flag_o, 1'b0);
        chk("R9", "count keeps running", count_o, 16'hFFFC);
        step(65540);
        chk("R9", "no second flag", flag_o, 1'b0);
        chk("R9", "count after second wrap", count_o, 16'hFFF8);
    endtask

    task automatic t_mode_switch();
        logic [15:0] held;
        held = count_o;
        pulse_mode = 1'b1;
        step(10);
        chk("R5", "frozen count", count_o, held);
        pulse_mode = 1'b0;
        step(1);
        chk("R6", "resume first step", count_o, held - 16'd1);
        step(2);
        chk("R6", "resume third step", count_o, held - 16'd3);
    endtask

    task automatic t_read_priority();
        wr(1'b0, 8'h03);
        wr(1'b1, 8'h00);
        step(4);
        lo_read = 1'b1;
        step(1);
        lo_read = 1'b0;
        chk("R10", "set wins over read", flag_o, 1'b1);
        chk("R10", "count at wrap", count_o, 16'hFFFF);
    endtask

    task automatic t_pulse();
        pulse_mode = 1'b1;
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h00);
        chk("R2", "load clears flag", flag_o, 1'b0);
        step(5);
        chk("R4", "no clock counting", count_o, 16'h0002);
        ext_pin = 1'b0;
        step(2);
        chk("R7", "before edge latency", count_o, 16'h0002);
        step(1);
        chk("R7", "after falling edge", count_o, 16'h0001);
        ext_pin = 1'b1;
        step(5);
        chk("R7", "rising edge ignored", count_o, 16'h0001);
        ext_pin = 1'b0;
        step(5);
        chk("R7", "second fall", count_o, 16'h0000);
        chk("R8", "flag before wrap", flag_o, 1'b0);
        ext_pin = 1'b1;
        step(5);
        ext_pin = 1'b0;
        step(5);
        chk("R8", "count wraps", count_o, 16'hFFFF);
        chk("R8", "flag on wrap", flag_o, 1'b1);
        ext_pin = 1'b1;
        step(5);
        wr(1'b0, 8'h77);
        chk("R1", "latch write keeps count", count_o, 16'hFFFF);
        chk("R1", "latch write keeps flag", flag_o, 1'b1);
        wr(1'b1, 8'h12);
        chk("R1", "latched low byte used", count_o, 16'h1277);
        chk("R2", "flag cleared by load", flag_o, 1'b0);
        step(4);
        chk("R4", "pin mode load holds", count_o, 16'h1277);
    endtask

    initial begin
        rst_n = 1'b0; pulse_mode = 1'b0; ext_pin = 1'b1;
        wr_en = 1'b0; wr_hi = 1'b0; wr_data = '0; lo_read = 1'b0;
        step(3);
        t_reset();
        t_timer();
        t_mode_switch();
        t_read_priority();
        t_pulse();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule